// File: doc/BRIEF.md
# Clock-Crossing Register Front End for a PWM Timer

This block sits between a bus and a PWM timer whose counter runs on its own clock. Software issues three kinds of commands that must reach the counter clock: restart the timebase, restart the spread-spectrum counter, and load a new duty value. Each accepted command is carried across with a toggle handshake. The bus side reports `busy` until the counter side acknowledges. A duty load is not acknowledged until the timebase next reaches its top, so the new value can never cause a glitch. Any crossing command that arrives while `busy` is high is dropped.

On the bus side there is also a small interrupt unit with two status bits. Bit 0 is the timebase overflow, raised from a top-of-count pulse that is synchronised back from the counter clock. Bit 1 is the ready flag, raised when `busy` drops. Software sets mask bits through an enable command, clears them through a disable command, and clears status bits through a status-clear command. The interrupt request follows the masked status. The waveform generator itself is outside this block: it appears only as the `top_strobe` input and as the reset pulses and duty outputs in the counter clock domain.

Top module: `pwm_sync_regif`

## Requirements
- R1: `wr_cmd` 0 (timebase restart) and 1 (spread-spectrum restart) each yield exactly one single-cycle pulse on `tb_rst_pulse` or `ss_rst_pulse` respectively, in the counter clock, per accepted write.
- R2: An accepted crossing write (`wr_en` high, `wr_cmd` 0, 1 or 2, `busy` low) raises `busy` at the next bus clock edge. `busy` stays high until the counter side acknowledges, which takes at least three bus cycles.
- R3: A write with `wr_cmd` 0, 1 or 2 made while `busy` is high is discarded: it produces no pulse, no duty change, and no extra busy period.
- R4: `wr_cmd` 2 (duty load) changes `duty_value` only on the counter edge that samples `top_strobe` high, with a one-cycle `duty_load` pulse. `busy` stays high until that load has been acknowledged.
- R5: Status bit 1 (ready) is set on the bus edge at which `busy` falls. A set event wins over a clear in the same cycle.
- R6: Status bit 0 (overflow) is set a few bus cycles after each `top_strobe` pulse, and at no other time.
- R7: `wr_cmd` 3 sets the mask bits where `wr_data[1:0]` is one. `wr_cmd` 4 clears them. Zero bits leave the mask unchanged.
- R8: `irq` is high exactly when some status bit and its mask bit are both set. `wr_cmd` 5 clears the status bits where `wr_data[1:0]` is one.
- R9: After reset `busy`, `status`, `mask`, `irq`, `duty_value` and the counter-side pulses are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Bus clock |
| rst_bus_n | input | 1 | Bus-domain reset, active low, synchronous |
| wr_en | input | 1 | Write strobe, one command per cycle |
| wr_cmd | input | 3 | Command code: 0 tb restart, 1 ss restart, 2 duty, 3 irq enable, 4 irq disable, 5 status clear |
| wr_data | input | DW | Duty value, or bit vector for commands 3 to 5 |
| busy | output | 1 | A crossing command is in flight |
| status | output | 2 | Bit 0 overflow, bit 1 ready |
| mask | output | 2 | Interrupt mask, same bit order as status |
| irq | output | 1 | Interrupt request |
| clk_cnt | input | 1 | Counter clock |
| rst_cnt_n | input | 1 | Counter-domain reset, active low, synchronous |
| top_strobe | input | 1 | Timebase reached its top this cycle |
| tb_rst_pulse | output | 1 | Restart the timebase counter |
| ss_rst_pulse | output | 1 | Restart the spread-spectrum counter |
| duty_load | output | 1 | `duty_value` was updated this cycle |
| duty_value | output | DW | Current duty value |

## Verification
The bench targets the following cases.

- **Writes issued while busy.** A second duty value and a timebase restart are written during a pending duty load. A design that does not drop them would load the wrong duty value or emit an extra restart pulse.
- **Early acknowledge of a duty load.** The bench holds off `top_strobe` for many cycles after the duty write. A design that acknowledges early would drop `busy` before any `duty_load`.
- **Set and clear ordering.** Ready and overflow are set, cleared, masked and unmasked while `irq` is compared on every cycle. A wrong set/clear priority, or an inverted disable, shows up as a mismatch on `irq` or `status`.
- **Zero-data writes.** The bench writes all-zero data to enable and clear. A design that writes those values through would lose mask or status bits.

// File: rtl/pwm_sif_pkg.sv
// Shared command codes and status bit positions for the PWM register front end.
package pwm_sif_pkg;
    typedef logic [2:0] cmd_t;

    localparam cmd_t CMD_TB_RST   = 3'd0;
    localparam cmd_t CMD_SS_RST   = 3'd1;
    localparam cmd_t CMD_DUTY     = 3'd2;
    localparam cmd_t CMD_IRQ_EN   = 3'd3;
    localparam cmd_t CMD_IRQ_DIS  = 3'd4;
    localparam cmd_t CMD_STAT_CLR = 3'd5;

    localparam int NST    = 2;
    localparam int ST_OVF = 0;
    localparam int ST_RDY = 1;
endpackage

// File: rtl/pwm_sif_sync.sv
// Multi-flop level synchronizer.
// Assumes the input is a level that holds for longer than STAGES destination cycles.
module pwm_sif_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the asynchronous level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/pwm_sif_bus.sv
// Bus-side half: accepts commands, owns the request toggle, busy, status, mask and irq.
// Assumes ack_s and ovf_s are already synchronized to clk. hold_cmd and hold_data
// stay constant while busy is high, so the counter side may sample them directly.
module pwm_sif_bus
    import pwm_sif_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  cmd_t           wr_cmd,
    input  logic [DW-1:0]  wr_data,
    input  logic           ack_s,
    input  logic           ovf_s,
    output logic           req_tgl,
    output cmd_t           hold_cmd,
    output logic [DW-1:0]  hold_data,
    output logic           busy,
    output logic [NST-1:0] status,
    output logic [NST-1:0] mask,
    output logic           irq
);
    logic           is_cross;
    logic           accept;
    logic           done;
    logic           ovf_last;
    logic [NST-1:0] set_vec;
    logic [NST-1:0] clr_vec;

    assign is_cross = (wr_cmd == CMD_TB_RST) || (wr_cmd == CMD_SS_RST) || (wr_cmd == CMD_DUTY);
    assign accept   = wr_en && is_cross && !busy;
    assign done     = busy && (ack_s == req_tgl);

    // Launch a request on acceptance and retire it when the acknowledge returns.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_tgl   <= 1'b0;
            busy      <= 1'b0;
            hold_cmd  <= CMD_TB_RST;
            hold_data <= '0;
        end else if (accept) begin
            req_tgl   <= ~req_tgl;
            busy      <= 1'b1;
            hold_cmd  <= wr_cmd;
            hold_data <= wr_data;
        end else if (done) begin
            busy      <= 1'b0;
        end
    end

    // Remember the last overflow toggle level to detect new top events.
    always_ff @(posedge clk) begin
        if (!rst_n) ovf_last <= 1'b0;
        else        ovf_last <= ovf_s;
    end

    always_comb begin
        set_vec         = '0;
        set_vec[ST_OVF] = ovf_s ^ ovf_last;
        set_vec[ST_RDY] = done;
        clr_vec         = (wr_en && wr_cmd == CMD_STAT_CLR) ? wr_data[NST-1:0] : '0;
    end

    // Status bits: set events take priority over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) status <= '0;
        else        status <= (status & ~clr_vec) | set_vec;
    end

    // Mask bits: enable writes set ones, disable writes clear ones.
    always_ff @(posedge clk) begin
        if (!rst_n)                                mask <= '0;
        else if (wr_en && wr_cmd == CMD_IRQ_EN)    mask <= mask | wr_data[NST-1:0];
        else if (wr_en && wr_cmd == CMD_IRQ_DIS)   mask <= mask & ~wr_data[NST-1:0];
    end

    assign irq = |(status & mask);
endmodule

// File: rtl/pwm_sif_cnt.sv
// Counter-side half: decodes each new request, emits restart pulses, and holds duty
// loads until the timebase top. Returns an acknowledge toggle for every completed
// command and an overflow toggle for every top strobe.
// Assumes req_s is synchronized to clk and hold_* are stable once req_s has changed.
module pwm_sif_cnt
    import pwm_sif_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_s,
    input  cmd_t          hold_cmd,
    input  logic [DW-1:0] hold_data,
    input  logic          top_strobe,
    output logic          ack_tgl,
    output logic          ovf_tgl,
    output logic          tb_rst_pulse,
    output logic          ss_rst_pulse,
    output logic          duty_load,
    output logic [DW-1:0] duty_value
);
    logic req_last;
    logic req_evt;
    logic pending;

    assign req_evt = req_s ^ req_last;

    // Execute requests; duty loads wait in pending for the next top strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_last     <= 1'b0;
            ack_tgl      <= 1'b0;
            pending      <= 1'b0;
            tb_rst_pulse <= 1'b0;
            ss_rst_pulse <= 1'b0;
            duty_load    <= 1'b0;
            duty_value   <= '0;
        end else begin
            req_last     <= req_s;
            tb_rst_pulse <= 1'b0;
            ss_rst_pulse <= 1'b0;
            duty_load    <= 1'b0;
            if (req_evt) begin
                case (hold_cmd)
                    CMD_TB_RST: begin tb_rst_pulse <= 1'b1; ack_tgl <= ~ack_tgl; end
                    CMD_SS_RST: begin ss_rst_pulse <= 1'b1; ack_tgl <= ~ack_tgl; end
                    default:    pending <= 1'b1;
                endcase
            end else if (pending && top_strobe) begin
                duty_value <= hold_data;
                duty_load  <= 1'b1;
                pending    <= 1'b0;
                ack_tgl    <= ~ack_tgl;
            end
        end
    end

    // Flip the overflow toggle once per top strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)          ovf_tgl <= 1'b0;
        else if (top_strobe) ovf_tgl <= ~ovf_tgl;
    end
endmodule

// File: rtl/pwm_sync_regif.sv
// Top level: bus-side register half, counter-side apply half, and three synchronizers
// (request into the counter clock; acknowledge and overflow back to the bus clock).
// Assumes the two resets are released so that both halves start from zero toggles.
module pwm_sync_regif
    import pwm_sif_pkg::*;
#(
    parameter int DW        = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic           clk_bus,
    input  logic           rst_bus_n,
    input  logic           wr_en,
    input  logic [2:0]     wr_cmd,
    input  logic [DW-1:0]  wr_data,
    output logic           busy,
    output logic [NST-1:0] status,
    output logic [NST-1:0] mask,
    output logic           irq,
    input  logic           clk_cnt,
    input  logic           rst_cnt_n,
    input  logic           top_strobe,
    output logic           tb_rst_pulse,
    output logic           ss_rst_pulse,
    output logic           duty_load,
    output logic [DW-1:0]  duty_value
);
    logic          req_tgl;
    logic          req_s;
    logic          ack_tgl;
    logic          ack_s;
    logic          ovf_tgl;
    logic          ovf_s;
    cmd_t          hold_cmd;
    logic [DW-1:0] hold_data;

    pwm_sif_bus #(.DW(DW)) u_bus (
        .clk(clk_bus), .rst_n(rst_bus_n), .wr_en(wr_en), .wr_cmd(wr_cmd),
        .wr_data(wr_data), .ack_s(ack_s), .ovf_s(ovf_s), .req_tgl(req_tgl),
        .hold_cmd(hold_cmd), .hold_data(hold_data), .busy(busy),
        .status(status), .mask(mask), .irq(irq)
    );

    pwm_sif_sync #(.STAGES(SYNC_STGS)) u_req_sync (
        .clk(clk_cnt), .rst_n(rst_cnt_n), .d(req_tgl), .q(req_s)
    );

    pwm_sif_sync #(.STAGES(SYNC_STGS)) u_ack_sync (
        .clk(clk_bus), .rst_n(rst_bus_n), .d(ack_tgl), .q(ack_s)
    );

    pwm_sif_sync #(.STAGES(SYNC_STGS)) u_ovf_sync (
        .clk(clk_bus), .rst_n(rst_bus_n), .d(ovf_tgl), .q(ovf_s)
    );

    pwm_sif_cnt #(.DW(DW)) u_cnt (
        .clk(clk_cnt), .rst_n(rst_cnt_n), .req_s(req_s), .hold_cmd(hold_cmd),
        .hold_data(hold_data), .top_strobe(top_strobe), .ack_tgl(ack_tgl),
        .ovf_tgl(ovf_tgl), .tb_rst_pulse(tb_rst_pulse), .ss_rst_pulse(ss_rst_pulse),
        .duty_load(duty_load), .duty_value(duty_value)
    );
endmodule

// File: rtl/pwm_sync_regif_chk.sv
// Port-level temporal checks for pwm_sync_regif, attached by bind.
module pwm_sync_regif_chk
    import pwm_sif_pkg::*;
#(
    parameter int DW = 8
) (
    input logic           clk_bus,
    input logic           rst_bus_n,
    input logic           wr_en,
    input logic [2:0]     wr_cmd,
    input logic [DW-1:0]  wr_data,
    input logic           busy,
    input logic [NST-1:0] status,
    input logic [NST-1:0] mask,
    input logic           clk_cnt,
    input logic           rst_cnt_n,
    input logic           top_strobe,
    input logic           tb_rst_pulse,
    input logic           duty_load,
    input logic [DW-1:0]  duty_value
);
    // R2
    busy_rise_chk: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        $rose(busy) |-> $past(wr_en && (wr_cmd <= CMD_DUTY)));

    // R5
    ready_on_fall_chk: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        $fell(busy) |-> status[ST_RDY]);

    // R7
    mask_set_chk: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (wr_en && wr_cmd == CMD_IRQ_EN) |=> ((mask & $past(wr_data[NST-1:0])) == $past(wr_data[NST-1:0])));

    // R7
    mask_clr_chk: assert property (@(posedge clk_bus) disable iff (!rst_bus_n)
        (wr_en && wr_cmd == CMD_IRQ_DIS) |=> ((mask & $past(wr_data[NST-1:0])) == '0));

    // R4
    duty_at_top_chk: assert property (@(posedge clk_cnt) disable iff (!rst_cnt_n)
        duty_load |-> $past(top_strobe));

    // R4
    duty_hold_chk: assert property (@(posedge clk_cnt) disable iff (!rst_cnt_n)
        !$stable(duty_value) |-> $past(top_strobe));

    // R1
    tb_pulse_single_chk: assert property (@(posedge clk_cnt) disable iff (!rst_cnt_n)
        tb_rst_pulse |=> !tb_rst_pulse);
endmodule

bind pwm_sync_regif pwm_sync_regif_chk #(.DW(DW)) u_chk (
    .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .wr_en(wr_en), .wr_cmd(wr_cmd),
    .wr_data(wr_data), .busy(busy), .status(status), .mask(mask),
    .clk_cnt(clk_cnt), .rst_cnt_n(rst_cnt_n), .top_strobe(top_strobe),
    .tb_rst_pulse(tb_rst_pulse), .duty_load(duty_load), .duty_value(duty_value)
);

// File: tb/test_pwm_sync_regif.sv
// Bench: behavioural reference of busy/status/mask/irq compared every bus cycle,
// counter-side pulses and duty loads compared every counter cycle.
module test_pwm_sync_regif;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DW = 8;

    logic          clk_bus = 1'b0;
    logic          clk_cnt = 1'b0;
    logic          rst_bus_n = 1'b0;
    logic          rst_cnt_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_cmd = 3'd0;
    logic [DW-1:0] wr_data = '0;
    logic          top_strobe = 1'b0;
    logic          busy, irq, tb_rst_pulse, ss_rst_pulse, duty_load;
    logic [1:0]    status, mask;
    logic [DW-1:0] duty_value;

    pwm_sync_regif #(.DW(DW)) i_pwm_sync_regif (
        .clk_bus(clk_bus), .rst_bus_n(rst_bus_n), .wr_en(wr_en), .wr_cmd(wr_cmd),
        .wr_data(wr_data), .busy(busy), .status(status), .mask(mask), .irq(irq),
        .clk_cnt(clk_cnt), .rst_cnt_n(rst_cnt_n), .top_strobe(top_strobe),
        .tb_rst_pulse(tb_rst_pulse), .ss_rst_pulse(ss_rst_pulse),
        .duty_load(duty_load), .duty_value(duty_value)
    );

    always #2 clk_bus = ~clk_bus;
    initial begin
        #0.5;
        forever #7 clk_cnt = ~clk_cnt;
    end

    int n_checks = 0;
    int n_errors = 0;

    task automatic chk(input bit ok, input string rq, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", rq, what, act, exp, $time);
        end
    endtask

    // Reference model state
    bit          m_busy = 0, busy_obs = 0, m_applied = 0, duty_wait = 0, exp_load = 0;
    bit          m_rdy = 0, m_ovf = 0;
    bit [1:0]    m_mask = 0;
    int          m_age = 0, m_kind = 0, ovf_recent = 0;
    int          tb_acc = 0, ss_acc = 0, tb_cnt = 0, ss_cnt = 0;
    logic [DW-1:0] exp_duty = '0, pend_duty = '0;
    bit          running = 0;

    // Apply this edge's inputs to the model (inputs are stable at the posedge).
    always @(posedge clk_bus) begin
        if (rst_bus_n && wr_en) begin
            case (wr_cmd)
                3'd0, 3'd1, 3'd2: if (!busy_obs) begin
                    m_busy = 1; m_age = 0; m_kind = int'(wr_cmd); m_applied = 0;
                    if (wr_cmd == 3'd0) tb_acc++;
                    if (wr_cmd == 3'd1) ss_acc++;
                    if (wr_cmd == 3'd2) begin pend_duty = wr_data; duty_wait = 1; end
                end
                3'd3: m_mask = m_mask | wr_data[1:0];
                3'd4: m_mask = m_mask & ~wr_data[1:0];
                3'd5: begin
                    if (wr_data[1]) m_rdy = 0;
                    if (wr_data[0]) m_ovf = 0;
                end
                default: ;
            endcase
        end
    end

    // Compare bus-side outputs every cycle.
    always @(negedge clk_bus) begin
        if (rst_bus_n && running) begin
            m_age++;
            if (ovf_recent > 0) ovf_recent--;
            if (busy_obs && !busy) begin
                if (m_kind == 2) chk(m_applied, "R4", "busy fell before duty load", 0, 1);
                else chk(m_age >= 3 && m_age <= 40, "R2", "busy fall latency", m_age, 3);
                m_busy = 0;
                m_rdy  = 1;   // R5
            end
            if (m_busy && m_age > 40 && (m_kind != 2 || m_applied)) begin
                chk(0, "R2", "busy never cleared", m_age, 40);
                m_busy = 0;
            end
            if (status[0] && !m_ovf) begin
                chk(ovf_recent > 0, "R6", "overflow without top strobe", 1, 0);
                m_ovf = 1;
            end
            chk(busy == m_busy, "R2", "busy", busy, m_busy);
            chk(status[1] == m_rdy, "R5", "ready", status[1], m_rdy);
            chk(status[0] == m_ovf, "R6", "overflow", status[0], m_ovf);
            chk(mask == m_mask, "R7", "mask", mask, m_mask);
            chk(irq == |({m_rdy, m_ovf} & m_mask), "R8", "irq", irq, |({m_rdy, m_ovf} & m_mask));
        end
        busy_obs = busy;
    end

    // Expect a duty load for the counter edge that sees top_strobe with a load pending.
    always @(posedge clk_cnt) begin
        exp_load = rst_cnt_n && top_strobe && duty_wait;
    end

    // Compare counter-side outputs every counter cycle.
    always @(negedge clk_cnt) begin
        if (rst_cnt_n && running) begin
            if (tb_rst_pulse) tb_cnt++;
            if (ss_rst_pulse) ss_cnt++;
            chk(tb_cnt <= tb_acc, "R1", "extra timebase pulse", tb_cnt, tb_acc);
            chk(ss_cnt <= ss_acc, "R1", "extra spread pulse", ss_cnt, ss_acc);
            chk(duty_load == exp_load, "R4", "duty_load timing", duty_load, exp_load);
            if (duty_load && exp_load) begin
                exp_duty = pend_duty; duty_wait = 0; m_applied = 1; m_age = 0;
            end
            chk(duty_value == exp_duty, "R4", "duty_value", duty_value, exp_duty);
        end
    end

    task automatic bus_wr(input logic [2:0] c, input logic [DW-1:0] d);
        @(negedge clk_bus);
        wr_en = 1'b1; wr_cmd = c; wr_data = d;
        @(negedge clk_bus);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic wait_bus(input int n);
        for (int i = 0; i < n; i++) @(negedge clk_bus);
    endtask

    task automatic pulse_top();
        @(negedge clk_cnt);
        top_strobe = 1'b1;
        ovf_recent = 30;
        @(negedge clk_cnt);
        top_strobe = 1'b0;
    endtask

    bit finished = 0;

    initial begin
        #400000;
        if (!finished) begin
            chk(0, "ALL", "watchdog expired", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        wait_bus(8);
        rst_bus_n = 1'b1; rst_cnt_n = 1'b1;
        running = 1;
        wait_bus(2);
        // R9: reset state
        chk(busy == 0 && status == 0 && mask == 0 && irq == 0, "R9", "bus outputs after reset",
            {busy, status, mask, irq}, 0);
        chk(duty_value == 0 && !tb_rst_pulse && !ss_rst_pulse && !duty_load, "R9",
            "counter outputs after reset", duty_value, 0);

        // R7: enable ready interrupt, zero write leaves mask alone
        bus_wr(3'd3, 8'h02);
        bus_wr(3'd3, 8'h00);
        wait_bus(2);
        chk(mask == 2'b10, "R7", "mask after enable and zero write", mask, 2);

        // R1/R2/R5: timebase restart
        bus_wr(3'd0, 8'h00);
        wait_bus(40);
        chk(tb_cnt == 1, "R1", "timebase pulses", tb_cnt, 1);
        chk(status[1] && irq, "R5", "ready raised irq", {status[1], irq}, 3);

        // R8: zero clear keeps status, one clears it
        bus_wr(3'd5, 8'h00);
        wait_bus(2);
        chk(status[1] == 1, "R8", "zero clear ignored", status[1], 1);
        bus_wr(3'd5, 8'h02);
        wait_bus(2);
        chk(!irq && status == 0, "R8", "irq after clear", irq, 0);

        // R1: spread-spectrum restart
        bus_wr(3'd1, 8'h00);
        wait_bus(40);
        chk(ss_cnt == 1, "R1", "spread pulses", ss_cnt, 1);

        // R3/R4: duty load held for top; writes during busy are dropped
        bus_wr(3'd2, 8'h55);
        bus_wr(3'd2, 8'hAA);
        bus_wr(3'd0, 8'h00);
        wait_bus(60);
        chk(busy == 1, "R4", "busy held until top", busy, 1);
        chk(duty_value == 0, "R4", "duty unchanged before top", duty_value, 0);
        pulse_top();
        wait_bus(40);
        chk(duty_value == 8'h55, "R3", "dropped duty write", duty_value, 8'h55);
        chk(tb_cnt == 1, "R3", "dropped timebase write", tb_cnt, 1);
        chk(busy == 0, "R4", "busy cleared after load", busy, 0);

        // R7: disable ready, R6: enable overflow
        bus_wr(3'd5, 8'h03);
        bus_wr(3'd4, 8'h02);
        bus_wr(3'd3, 8'h01);
        bus_wr(3'd0, 8'h00);
        wait_bus(40);
        chk(status[1] == 1 && irq == 0, "R7", "masked ready gives no irq", irq, 0);
        pulse_top();
        wait_bus(20);
        chk(status[0] == 1 && irq == 1, "R6", "overflow raises irq", {status[0], irq}, 3);
        chk(duty_value == 8'h55, "R4", "no load without pending duty", duty_value, 8'h55);
        bus_wr(3'd5, 8'h01);
        wait_bus(2);
        chk(status[0] == 0 && irq == 0, "R8", "overflow cleared", status[0], 0);

        // Second duty load back to back
        bus_wr(3'd2, 8'h0F);
        wait_bus(30);
        pulse_top();
        wait_bus(40);
        chk(duty_value == 8'h0F, "R4", "second duty load", duty_value, 8'h0F);
        chk(tb_cnt == tb_acc && ss_cnt == ss_acc, "R1", "pulse totals", tb_cnt + ss_cnt, tb_acc + ss_acc);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule